// File: doc/BRIEF.md
# Prioritized CAN Transmit Scheduler

This block decides which message object the CAN shift register sends next. Each object has a valid flag and a transmit-request flag. When the shift register is ready and no transfer between the host buffers and message RAM is under way, the block picks the pending valid object with the lowest index. It issues a one-cycle load pulse carrying that index. After this only one transmission is in flight, and no further choice is made until the transmitter reports success or failure.

Per-object status is kept here and driven out as vectors. The status holds the transmit request, a new-data marker and a pending transmit interrupt. A host write sets an object's new-data marker and may also raise its request. A successful send clears the request only when no fresh data reached the object during the send. It also raises the interrupt when that object's interrupt enable is set. A failed send leaves the request standing, so the object competes again by priority on the next free slot.

Top module: `can_tx_sched`

## Requirements
- R1: After reset the request, new-data and interrupt-pending vectors are all zero and no load pulse is produced.
- R2: A load pulse occurs only in a cycle where `sr_ready` is 1, `xfer_busy` is 0 and no transmission is in flight.
- R3: An object is eligible only when both its `obj_valid` bit and its `txrqst` bit are 1.
- R4: Among eligible objects, the one with the lowest index is loaded, and `load_idx` carries its binary index.
- R5: The clock edge that ends a load pulse clears the loaded object's `newdat` bit, unless a host write to that object occurs in the same cycle.
- R6: `tx_ok` during a transmission clears the object's `txrqst` if its `newdat` is still 0 and no host write to it occurs in that cycle.
- R7: If the object was written during its transmission (`newdat` is 1), `tx_ok` leaves its `txrqst` set.
- R8: `tx_ok` sets the object's `intpnd` bit when `obj_txie` for it is 1, and leaves it unchanged when it is 0. A 1 on `int_clr[i]` clears `intpnd[i]`.
- R9: `tx_fail` ends the transmission and keeps `txrqst` set. The next load again picks by priority, so a lower-index request raised meanwhile goes first.
- R10: A load pulse lasts one cycle, and no further pulse occurs until `tx_ok` or `tx_fail` ends the transmission.
- R11: A host write (`wr_en`) sets `newdat[wr_idx]`, and also sets `txrqst[wr_idx]` when `wr_rqst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| obj_valid | input | N | Per-object valid flags |
| obj_txie | input | N | Per-object transmit-interrupt enables |
| wr_en | input | 1 | Host write strobe to one object |
| wr_idx | input | IW | Object index of the host write |
| wr_rqst | input | 1 | Host write also raises the transmit request |
| int_clr | input | N | Per-object interrupt-pending clear |
| xfer_busy | input | 1 | Buffer-to-RAM transfer in progress |
| sr_ready | input | 1 | Shift register can accept a frame |
| tx_ok | input | 1 | Transmission finished successfully |
| tx_fail | input | 1 | Arbitration lost or error during transmission |
| load | output | 1 | One-cycle load pulse to the shift register |
| load_idx | output | IW | Index of the object being loaded |
| txrqst | output | N | Per-object transmit requests |
| newdat | output | N | Per-object new-data markers |
| intpnd | output | N | Per-object interrupt-pending flags |

## Verification
The assertions assume that `tx_ok` and `tx_fail` are never high together. They also assume that these two strobes come only while a transmission is in flight, that is, after a load pulse and before the matching completion. The stimulus respects this. Every completion strobe is issued only after the bench has seen a load pulse, and each strobe lasts a single cycle. The bench holds `sr_ready` low while it sets objects up, so that the only loads are the ones a scenario expects.

// File: rtl/can_tx_sched.sv
module can_tx_sched #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  obj_valid,
  input  logic [N-1:0]  obj_txie,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_rqst,
  input  logic [N-1:0]  int_clr,
  input  logic          xfer_busy,
  input  logic          sr_ready,
  input  logic          tx_ok,
  input  logic          tx_fail,
  output logic          load,
  output logic [IW-1:0] load_idx,
  output logic [N-1:0]  txrqst,
  output logic [N-1:0]  newdat,
  output logic [N-1:0]  intpnd
);

  logic          inflight;
  logic [IW-1:0] cur;
  logic [N-1:0]  cand, rq_n, nd_n, ip_n;
  logic [IW-1:0] sel;
  logic          done_ok, wr_cur;

  assign cand    = obj_valid & txrqst;
  assign load    = sr_ready && !xfer_busy && !inflight && (|cand);
  assign load_idx = sel;
  assign done_ok = inflight && tx_ok;
  assign wr_cur  = wr_en && (wr_idx == cur);

  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--)
      if (cand[i]) sel = i[IW-1:0];
  end

  always_comb begin
    rq_n = txrqst;
    nd_n = newdat;
    ip_n = intpnd & ~int_clr;
    if (done_ok) begin
      if (!newdat[cur] && !wr_cur) rq_n[cur] = 1'b0;
      if (obj_txie[cur]) ip_n[cur] = 1'b1;
    end
    if (load) nd_n[sel] = 1'b0;
    if (wr_en) begin
      nd_n[wr_idx] = 1'b1;
      if (wr_rqst) rq_n[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inflight <= 1'b0;
      cur      <= '0;
      txrqst   <= '0;
      newdat   <= '0;
      intpnd   <= '0;
    end else begin
      txrqst <= rq_n;
      newdat <= nd_n;
      intpnd <= ip_n;
      if (load) begin
        inflight <= 1'b1;
        cur      <= sel;
      end else if (inflight && (tx_ok || tx_fail)) begin
        inflight <= 1'b0;
      end
    end
  end

  assert_load_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (sr_ready && !xfer_busy));

  assert_load_cand_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (obj_valid[load_idx] && txrqst[load_idx]));

  assert_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> ((obj_valid & txrqst & ~({N{1'b1}} << load_idx)) == '0));

  assert_newdat_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !(wr_en && wr_idx == load_idx)) |=> !newdat[$past(load_idx)]);

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load);

  assert_hold_until_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight && !tx_ok && !tx_fail) |=> !load);

endmodule

// File: tb/sim_can_tx_sched.sv
module sim_can_tx_sched;
  localparam int PERIOD = 10;
  localparam int N = 32;
  localparam int IW = 5;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] obj_valid = '0, obj_txie = '0, int_clr = '0;
  logic wr_en = 0, wr_rqst = 0, xfer_busy = 0, sr_ready = 0, tx_ok = 0, tx_fail = 0;
  logic [IW-1:0] wr_idx = '0;
  logic load;
  logic [IW-1:0] load_idx;
  logic [N-1:0] txrqst, newdat, intpnd;
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  can_tx_sched #(.N(N), .IW(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .obj_valid(obj_valid), .obj_txie(obj_txie),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_rqst(wr_rqst), .int_clr(int_clr),
    .xfer_busy(xfer_busy), .sr_ready(sr_ready), .tx_ok(tx_ok), .tx_fail(tx_fail),
    .load(load), .load_idx(load_idx), .txrqst(txrqst), .newdat(newdat), .intpnd(intpnd));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(int idx, bit rq);
    @(negedge clk); wr_en = 1; wr_idx = idx[IW-1:0]; wr_rqst = rq;
    @(negedge clk); wr_en = 0; wr_rqst = 0;
  endtask

  task automatic expect_load(string req, int idx);
    @(negedge clk); sr_ready = 1; #1;
    chk(req, {63'd0, load}, 64'd1);
    chk(req, {59'd0, load_idx}, idx);
    @(negedge clk); #1;
    chk("R10", {63'd0, load}, 64'd0);
    sr_ready = 0;
  endtask

  task automatic finish_tx(bit ok);
    @(negedge clk); tx_ok = ok; tx_fail = !ok;
    @(negedge clk); tx_ok = 0; tx_fail = 0;
  endtask

  task automatic t_reset;
    sr_ready = 1; #1;
    chk("R1", {63'd0, load}, 0);
    chk("R1", {32'd0, txrqst}, 0);
    chk("R1", {32'd0, newdat}, 0);
    chk("R1", {32'd0, intpnd}, 0);
    sr_ready = 0;
  endtask

  task automatic t_basic;
    obj_valid = '1; obj_txie = 32'h0000_0020;
    host_wr(9, 1); host_wr(5, 1);
    chk("R11", {32'd0, newdat}, 64'h220);
    chk("R11", {32'd0, txrqst}, 64'h220);
    @(negedge clk); xfer_busy = 1; sr_ready = 1; #1;
    chk("R2", {63'd0, load}, 0);
    @(negedge clk); xfer_busy = 0; sr_ready = 0;
    expect_load("R4", 5);
    chk("R5", {63'd0, newdat[5]}, 0);
    @(negedge clk); sr_ready = 1; #1;
    chk("R10", {63'd0, load}, 0);
    sr_ready = 0;
    finish_tx(1);
    chk("R6", {63'd0, txrqst[5]}, 0);
    chk("R8", {63'd0, intpnd[5]}, 1);
    expect_load("R4", 9);
    finish_tx(1);
    chk("R6", {63'd0, txrqst[9]}, 0);
    chk("R8", {63'd0, intpnd[9]}, 0);
    @(negedge clk); int_clr = 32'h20;
    @(negedge clk); int_clr = '0;
    chk("R8", {63'd0, intpnd[5]}, 0);
  endtask

  task automatic t_invalid;
    obj_valid = '1; obj_valid[2] = 0;
    host_wr(2, 1);
    @(negedge clk); sr_ready = 1; #1;
    chk("R3", {63'd0, load}, 0);
    sr_ready = 0;
    obj_valid[2] = 1;
    expect_load("R3", 2);
    finish_tx(1);
    chk("R6", {63'd0, txrqst[2]}, 0);
  endtask

  task automatic t_newdat;
    host_wr(3, 1);
    expect_load("R4", 3);
    host_wr(3, 0);
    finish_tx(1);
    chk("R7", {63'd0, txrqst[3]}, 1);
    chk("R7", {63'd0, newdat[3]}, 1);
    expect_load("R7", 3);
    finish_tx(1);
    chk("R6", {63'd0, txrqst[3]}, 0);
  endtask

  task automatic t_fail;
    host_wr(10, 1);
    expect_load("R9", 10);
    host_wr(4, 1);
    finish_tx(0);
    chk("R9", {63'd0, txrqst[10]}, 1);
    expect_load("R9", 4);
    finish_tx(1);
    expect_load("R9", 10);
    finish_tx(1);
    chk("R9", {32'd0, txrqst}, 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_invalid;
    t_newdat;
    t_fail;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule